// File: doc/BRIEF.md
# Exception Stack Frame Push Sequencer

This block produces the series of stack writes that a processor core makes when it hands control to an interrupt or exception handler. A start pulse captures a description of the event: operating mode (legacy or 64-bit), gate size (16-bit or 32-bit, legacy only), whether the privilege level changes, where the event came from (an external pin, a software interrupt instruction or an internal exception), and whether an error code exists along with its selector fields. It also captures the values to save: old stack segment, old stack pointer, flags, code segment and instruction pointer. The block then issues one stack write per cycle, each carrying an address, data and byte size.

Each write stays on the outputs until the memory side accepts it. After the final write the block raises a one-cycle done pulse, which carries the final stack pointer and the stack segment selector the core should load next. The block looks up no descriptors, checks no privilege rules and does not handle the return path.

Top module: `exc_frame_pusher`

## Requirements
- R1: The error code word has EXT in bit 0, the table flag in bit 1, the local-table flag in bit 2 and the 13-bit selector index in bits 15:3. Every bit above 15 is zero. With index, table and local-table fields all zero, the word is zero except possibly bit 0.
- R2: An error code is pushed only when `ec_valid` is 1 and `src` is 0 (internal exception). It is never pushed for `src` 1 (external pin) or `src` 2 (software interrupt), even when `ec_valid` is 1.
- R3: In legacy mode (`mode64`=0) every push is 2 bytes when `gate32`=0 and 4 bytes when `gate32`=1. Each pushed value is truncated to that width.
- R4: In 64-bit mode every push is 8 bytes, and narrower values are zero-extended to 64 bits.
- R5: The old stack segment and old stack pointer are pushed whenever `mode64`=1. When `mode64`=0 they are pushed only if `priv_chg`=1.
- R6: `new_ss` is 0 when `mode64` and `priv_chg` are both 1. It is `new_ss_in` when only `priv_chg` is 1, and `old_ss` when `priv_chg` is 0.
- R7: Pushes run in the order stack segment, stack pointer, flags, code segment, instruction pointer, error code, leaving out any entry that is not pushed. Each push first lowers the stack pointer by the push size, then writes at the new value.
- R8: `wr_valid` rises in the cycle after start is captured. A write with `wr_ready`=0 keeps its address, data and size unchanged until it is accepted.
- R9: `done` is high for exactly one cycle, in the cycle after the last accepted write. During that cycle `final_sp` equals the address of the last write.
- R10: While `busy` is 1, a start pulse is ignored. The run in progress keeps going unchanged and no extra writes are issued.
- R11: The first push begins from `new_sp` when the old stack is pushed, and from `old_sp` otherwise.
- R12: After reset, `wr_valid`, `done` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame; sampled only when idle |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = legacy |
| gate32 | input | 1 | Legacy gate size: 1 = 32-bit, 0 = 16-bit |
| priv_chg | input | 1 | Privilege level changes with this event |
| src | input | 2 | Event source: 0 internal exception, 1 external pin, 2 software interrupt |
| ec_valid | input | 1 | Vector carries an error code |
| ec_ext | input | 1 | Error code external-event bit |
| ec_idt | input | 1 | Error code table flag |
| ec_ti | input | 1 | Error code local-table flag |
| ec_index | input | IDXW | Error code selector index |
| old_ss | input | 16 | Interrupted stack segment selector |
| new_ss_in | input | 16 | Stack segment selector for the handler stack |
| old_sp | input | AW | Interrupted stack pointer |
| new_sp | input | AW | Handler stack pointer |
| old_flags | input | FLW | Flags to save |
| old_cs | input | 16 | Code segment selector to save |
| old_ip | input | AW | Instruction pointer to save |
| wr_ready | input | 1 | Memory side accepts the current write |
| wr_valid | output | 1 | A write is presented |
| wr_addr | output | AW | Write byte address |
| wr_data | output | DW | Write data, zero above the size |
| wr_size | output | SZW | Write size in bytes (2, 4 or 8) |
| done | output | 1 | One-cycle completion pulse |
| final_sp | output | AW | Stack pointer after the frame, valid with done |
| new_ss | output | 16 | Stack segment selector to load, valid with done |
| busy | output | 1 | A frame is in progress |

## Verification
The first write is due in the cycle after the rising clock edge that samples start. Each later write is due in the cycle after the edge where the previous write was accepted, and done is due one cycle after the last accepted write. A behavioural model in the bench sees the same inputs at each falling edge. It first compares the outputs the design is holding in that cycle, then advances its own state by one edge. Inputs change just after rising edges, so every comparison falls midway between the edge that produced a result and the edge that consumes it.

// File: rtl/exc_frame_pkg.sv
package exc_frame_pkg;

   typedef enum logic [1:0] {
      SRC_EXC = 2'd0,
      SRC_PIN = 2'd1,
      SRC_SWI = 2'd2
   } src_e;

   localparam int SELW    = 16;
   localparam int NSLOT   = 6;
   localparam int SLOT_SS = 0;
   localparam int SLOT_SP = 1;
   localparam int SLOT_FL = 2;
   localparam int SLOT_CS = 3;
   localparam int SLOT_IP = 4;
   localparam int SLOT_EC = 5;

endpackage

// File: rtl/exc_err_code.sv
module exc_err_code
   import exc_frame_pkg::*;
#(
   parameter int DW   = 64,
   parameter int IDXW = 13
) (
   input  logic            ext,
   input  logic            idt,
   input  logic            ti,
   input  logic [IDXW-1:0] index,
   output logic [DW-1:0]   code
);
   localparam int CODEW = 3 + IDXW;

   if (CODEW != SELW) begin : g_bad_idxw
      $error("exc_err_code: index must fill bits 15:3 exactly");
   end

   always_comb begin
      code = '0;
      code[CODEW-1:0] = {index, ti, idt, ext};
   end

endmodule

// File: rtl/exc_frame_plan.sv
module exc_frame_plan
   import exc_frame_pkg::*;
#(
   parameter int AW  = 64,
   parameter int SZW = 4
) (
   input  logic             mode64,
   input  logic             gate32,
   input  logic             priv_chg,
   input  logic [1:0]       src,
   input  logic             ec_valid,
   input  logic [AW-1:0]    old_sp,
   input  logic [AW-1:0]    new_sp,
   input  logic [SELW-1:0]  old_ss,
   input  logic [SELW-1:0]  new_ss_in,
   output logic [NSLOT-1:0] mask,
   output logic [SZW-1:0]   size,
   output logic [AW-1:0]    start_sp,
   output logic [SELW-1:0]  ss_out
);
   logic push_old;
   logic push_ec;

   always_comb begin
      push_old = mode64 | priv_chg;
      push_ec  = ec_valid && (src_e'(src) == SRC_EXC);

      mask          = '0;
      mask[SLOT_SS] = push_old;
      mask[SLOT_SP] = push_old;
      mask[SLOT_FL] = 1'b1;
      mask[SLOT_CS] = 1'b1;
      mask[SLOT_IP] = 1'b1;
      mask[SLOT_EC] = push_ec;

      if (mode64)      size = SZW'(8);
      else if (gate32) size = SZW'(4);
      else             size = SZW'(2);

      start_sp = push_old ? new_sp : old_sp;

      if (!priv_chg)   ss_out = old_ss;
      else if (mode64) ss_out = '0;
      else             ss_out = new_ss_in;
   end

endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
   import exc_frame_pkg::*;
#(
   parameter int AW  = 64,
   parameter int DW  = 64,
   parameter int SZW = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      mode64,
   input  logic [NSLOT-1:0]          mask,
   input  logic [SZW-1:0]            size,
   input  logic [AW-1:0]             start_sp,
   input  logic [SELW-1:0]           ss_in,
   input  logic [NSLOT-1:0][DW-1:0]  vals_in,
   input  logic                      wr_ready,
   output logic                      wr_valid,
   output logic [AW-1:0]             wr_addr,
   output logic [DW-1:0]             wr_data,
   output logic [SZW-1:0]            wr_size,
   output logic                      done,
   output logic [AW-1:0]             final_sp,
   output logic [SELW-1:0]           new_ss,
   output logic                      busy
);
   localparam int NBYTE = DW / 8;

   typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_DONE} st_e;

   st_e                      st_q;
   logic [NSLOT-1:0]         rem_q;
   logic [SZW-1:0]           sz_q;
   logic [AW-1:0]            sp_q;
   logic [SELW-1:0]          ss_q;
   logic                     m64_q;
   logic [NSLOT-1:0][DW-1:0] vals_q;

   logic [NSLOT-1:0] below;
   logic [NSLOT-1:0] pick;
   logic [NSLOT-1:0] rem_next;
   logic [DW-1:0]    sel_val;
   logic [DW-1:0]    bmask;

   // lowest remaining slot wins
   assign below[0] = 1'b0;
   assign pick[0]  = rem_q[0];
   for (genvar i = 1; i < NSLOT; i++) begin : g_pick
      assign below[i] = below[i-1] | rem_q[i-1];
      assign pick[i]  = rem_q[i] & ~below[i];
   end

   for (genvar b = 0; b < NBYTE; b++) begin : g_bmask
      assign bmask[b*8 +: 8] = (SZW'(b) < sz_q) ? 8'hFF : 8'h00;
   end

   always_comb begin
      sel_val = '0;
      for (int i = 0; i < NSLOT; i++) begin
         if (pick[i]) sel_val = sel_val | vals_q[i];
      end
   end

   assign rem_next = rem_q & ~pick;
   assign wr_valid = (st_q == ST_PUSH);
   assign wr_addr  = sp_q - AW'(sz_q);
   assign wr_data  = sel_val & bmask;
   assign wr_size  = sz_q;
   assign done     = (st_q == ST_DONE);
   assign busy     = (st_q != ST_IDLE);
   assign final_sp = sp_q;
   assign new_ss   = ss_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         rem_q  <= '0;
         sz_q   <= '0;
         sp_q   <= '0;
         ss_q   <= '0;
         m64_q  <= 1'b0;
         vals_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (start) begin
               rem_q  <= mask;
               sz_q   <= size;
               sp_q   <= start_sp;
               ss_q   <= ss_in;
               m64_q  <= mode64;
               vals_q <= vals_in;
               st_q   <= ST_PUSH;
            end
            ST_PUSH: if (wr_ready) begin
               sp_q  <= wr_addr;
               rem_q <= rem_next;
               if (rem_next == '0) st_q <= ST_DONE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_size));

   p_size64_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && m64_q |-> wr_size == SZW'(8));

   p_sizeleg_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !m64_q |-> (wr_size == SZW'(2) || wr_size == SZW'(4)));

   p_ec_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && pick[SLOT_EC] |-> wr_data[DW-1:SELW] == '0);

   p_predec_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && wr_ready |=> !wr_valid || wr_addr == $past(wr_addr) - AW'(wr_size));

   p_done_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(wr_valid && wr_ready));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_final_sp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> final_sp == $past(wr_addr));

   p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready && start |=> $stable(wr_addr) && $stable(wr_size));

endmodule

// File: rtl/exc_frame_pusher.sv
module exc_frame_pusher
   import exc_frame_pkg::*;
#(
   parameter int AW   = 64,
   parameter int DW   = 64,
   parameter int FLW  = 32,
   parameter int IDXW = 13,
   parameter int SZW  = $clog2(DW / 8) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             mode64,
   input  logic             gate32,
   input  logic             priv_chg,
   input  logic [1:0]       src,
   input  logic             ec_valid,
   input  logic             ec_ext,
   input  logic             ec_idt,
   input  logic             ec_ti,
   input  logic [IDXW-1:0]  ec_index,
   input  logic [SELW-1:0]  old_ss,
   input  logic [SELW-1:0]  new_ss_in,
   input  logic [AW-1:0]    old_sp,
   input  logic [AW-1:0]    new_sp,
   input  logic [FLW-1:0]   old_flags,
   input  logic [SELW-1:0]  old_cs,
   input  logic [AW-1:0]    old_ip,
   input  logic             wr_ready,
   output logic             wr_valid,
   output logic [AW-1:0]    wr_addr,
   output logic [DW-1:0]    wr_data,
   output logic [SZW-1:0]   wr_size,
   output logic             done,
   output logic [AW-1:0]    final_sp,
   output logic [SELW-1:0]  new_ss,
   output logic             busy
);
   if (DW != 64) begin : g_bad_dw
      $error("exc_frame_pusher: data path must be 8 bytes wide");
   end
   if (AW > DW || AW < 32) begin : g_bad_aw
      $error("exc_frame_pusher: address width must lie between 32 and DW");
   end
   if (FLW > DW) begin : g_bad_flw
      $error("exc_frame_pusher: flags wider than data path");
   end

   logic [NSLOT-1:0]         mask;
   logic [SZW-1:0]           size;
   logic [AW-1:0]            start_sp;
   logic [SELW-1:0]          ss_plan;
   logic [DW-1:0]            ec_word;
   logic [NSLOT-1:0][DW-1:0] vals;

   exc_err_code #(.DW(DW), .IDXW(IDXW)) u_ec (
      .ext   (ec_ext),
      .idt   (ec_idt),
      .ti    (ec_ti),
      .index (ec_index),
      .code  (ec_word)
   );

   exc_frame_plan #(.AW(AW), .SZW(SZW)) u_plan (
      .mode64    (mode64),
      .gate32    (gate32),
      .priv_chg  (priv_chg),
      .src       (src),
      .ec_valid  (ec_valid),
      .old_sp    (old_sp),
      .new_sp    (new_sp),
      .old_ss    (old_ss),
      .new_ss_in (new_ss_in),
      .mask      (mask),
      .size      (size),
      .start_sp  (start_sp),
      .ss_out    (ss_plan)
   );

   always_comb begin
      vals          = '0;
      vals[SLOT_SS] = DW'(old_ss);
      vals[SLOT_SP] = DW'(old_sp);
      vals[SLOT_FL] = DW'(old_flags);
      vals[SLOT_CS] = DW'(old_cs);
      vals[SLOT_IP] = DW'(old_ip);
      vals[SLOT_EC] = ec_word;
   end

   exc_frame_seq #(.AW(AW), .DW(DW), .SZW(SZW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .mode64   (mode64),
      .mask     (mask),
      .size     (size),
      .start_sp (start_sp),
      .ss_in    (ss_plan),
      .vals_in  (vals),
      .wr_ready (wr_ready),
      .wr_valid (wr_valid),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .wr_size  (wr_size),
      .done     (done),
      .final_sp (final_sp),
      .new_ss   (new_ss),
      .busy     (busy)
   );

   p_reset_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !wr_valid && !done);

endmodule

// File: tb/exc_frame_pusher_bench.sv
module exc_frame_pusher_bench;
   localparam int AW = 64, DW = 64, FLW = 32, IDXW = 13, SZW = 4;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n = 1'b0, start = 1'b0, mode64 = 1'b0, gate32 = 1'b0, priv_chg = 1'b0;
   logic [1:0] src = 2'd0;
   logic ec_valid = 1'b0, ec_ext = 1'b0, ec_idt = 1'b0, ec_ti = 1'b0;
   logic [IDXW-1:0] ec_index = '0;
   logic [15:0] old_ss = '0, new_ss_in = '0, old_cs = '0;
   logic [AW-1:0] old_sp = '0, new_sp = '0, old_ip = '0;
   logic [FLW-1:0] old_flags = '0;
   logic wr_ready = 1'b1;
   logic wr_valid, done, busy;
   logic [AW-1:0] wr_addr, final_sp;
   logic [DW-1:0] wr_data;
   logic [SZW-1:0] wr_size;
   logic [15:0] new_ss;

   exc_frame_pusher u_exc_frame_pusher (.*);

   int n_cmp = 0, n_bad = 0;
   bit stall_en = 1'b0, model_on = 1'b0;
   int dut_writes = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // reference model
   int m_st = 0;
   logic [63:0] q_addr[$], q_data[$], q_size[$];
   string q_atag[$], q_dtag[$], q_stag[$];
   logic [63:0] m_final, m_ss, m_sp;

   task automatic add_push(input logic [63:0] v, input int sz, input bit m64,
                           input string dtag, input bit first);
      logic [63:0] mk;
      mk = (sz == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 * sz)) - 64'd1);
      m_sp = m_sp - 64'(sz);
      q_addr.push_back(m_sp);
      q_data.push_back(v & mk);
      q_size.push_back(64'(sz));
      q_atag.push_back(first ? "R11" : "R7");
      q_dtag.push_back(dtag);
      q_stag.push_back(m64 ? "R4" : "R3");
   endtask

   task automatic build_model();
      int sz;
      bit po;
      string w;
      sz = mode64 ? 8 : (gate32 ? 4 : 2);
      po = mode64 || priv_chg;
      w  = mode64 ? "R4" : "R3";
      m_sp = po ? new_sp : old_sp;
      if (po) begin
         add_push(64'(old_ss), sz, mode64, "R5", 1'b1);
         add_push(64'(old_sp), sz, mode64, "R5", 1'b0);
      end
      add_push(64'(old_flags), sz, mode64, w, !po);
      add_push(64'(old_cs), sz, mode64, w, 1'b0);
      add_push(old_ip, sz, mode64, w, 1'b0);
      if (ec_valid && src == 2'd0)
         add_push({48'd0, ec_index, ec_ti, ec_idt, ec_ext}, sz, mode64, "R1", 1'b0);
      m_ss = !priv_chg ? 64'(old_ss) : (mode64 ? 64'd0 : 64'(new_ss_in));
   endtask

   always @(negedge clk) begin
      if (rst_n && model_on) begin
         chk(wr_valid === (m_st == 1), "R8", "wr_valid", 64'(wr_valid), 64'(m_st == 1));
         chk(busy === (m_st != 0), "R10", "busy", 64'(busy), 64'(m_st != 0));
         chk(done === (m_st == 2), "R9", "done", 64'(done), 64'(m_st == 2));
         if (m_st == 1 && wr_valid === 1'b1) begin
            chk(wr_addr === q_addr[0], q_atag[0], "wr_addr", wr_addr, q_addr[0]);
            chk(wr_data === q_data[0], q_dtag[0], "wr_data", wr_data, q_data[0]);
            chk(64'(wr_size) === q_size[0], q_stag[0], "wr_size", 64'(wr_size), q_size[0]);
         end
         if (m_st == 2 && done === 1'b1) begin
            chk(final_sp === m_final, "R9", "final_sp", final_sp, m_final);
            chk(64'(new_ss) === m_ss, "R6", "new_ss", 64'(new_ss), m_ss);
         end
         if (wr_valid === 1'b1 && wr_ready) dut_writes++;
         case (m_st)
            0: if (start) begin build_model(); m_st = 1; end
            1: if (wr_ready) begin
               m_final = q_addr[0];
               void'(q_addr.pop_front()); void'(q_data.pop_front()); void'(q_size.pop_front());
               void'(q_atag.pop_front()); void'(q_dtag.pop_front()); void'(q_stag.pop_front());
               if (q_addr.size() == 0) m_st = 2;
            end
            default: m_st = 0;
         endcase
      end
   end

   always @(posedge clk) begin
      #1 wr_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
   end

   task automatic run(input bit m64, input bit g32, input bit pc, input logic [1:0] s,
                      input bit ecv, input bit ex, input bit idt, input bit ti,
                      input logic [IDXW-1:0] idx, input bit stl, input bit again);
      int exp_n;
      @(posedge clk); #1;
      mode64 = m64; gate32 = g32; priv_chg = pc; src = s;
      ec_valid = ecv; ec_ext = ex; ec_idt = idt; ec_ti = ti; ec_index = idx;
      old_ss = 16'($urandom); new_ss_in = 16'($urandom); old_cs = 16'($urandom);
      old_sp = {32'h0000_7FFF, 20'($urandom), 12'h800};
      new_sp = {32'h0000_4000, 20'($urandom), 12'h000};
      old_ip = {$urandom, $urandom};
      old_flags = $urandom;
      stall_en = stl;
      dut_writes = 0;
      exp_n = 3 + ((m64 || pc) ? 2 : 0) + ((ecv && s == 2'd0) ? 1 : 0);
      start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      if (again) begin
         @(posedge clk); #1 start = 1'b1;   // R10: ignored while busy
         @(posedge clk); #1 start = 1'b0;
      end
      do @(negedge clk); while (done !== 1'b1);
      @(negedge clk); @(negedge clk);
      chk(dut_writes == exp_n, "R2", "write count", 64'(dut_writes), 64'(exp_n));
      chk(busy === 1'b0, "R10", "idle after run", 64'(busy), 64'd0);
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(wr_valid === 1'b0, "R12", "wr_valid after reset", 64'(wr_valid), 64'd0);
      chk(done === 1'b0, "R12", "done after reset", 64'(done), 64'd0);
      chk(busy === 1'b0, "R12", "busy after reset", 64'(busy), 64'd0);
      model_on = 1'b1;
      // legacy 16-bit, no privilege change, exception with error code
      run(0, 0, 0, 2'd0, 1, 0, 1, 0, 13'h0123, 0, 0);
      // legacy 32-bit, privilege change, error code, stalls
      run(0, 1, 1, 2'd0, 1, 1, 0, 1, 13'h1FFF, 1, 0);
      // legacy 32-bit, pin source with ec_valid: no error code (R2)
      run(0, 1, 1, 2'd1, 1, 0, 0, 0, 13'h0042, 0, 0);
      // 64-bit, no privilege change: old stack still pushed (R5)
      run(1, 0, 0, 2'd1, 0, 0, 0, 0, 13'h0000, 0, 0);
      // 64-bit, privilege change, software interrupt: null SS (R6), no code
      run(1, 1, 1, 2'd2, 1, 1, 1, 1, 13'h0AAA, 1, 0);
      // 64-bit null error code with EXT only (R1)
      run(1, 0, 1, 2'd0, 1, 1, 0, 0, 13'h0000, 1, 0);
      // start while busy ignored (R10)
      run(0, 0, 1, 2'd0, 1, 0, 0, 0, 13'h0555, 1, 1);
      run(1, 0, 0, 2'd0, 1, 0, 1, 1, 13'h1234, 0, 1);
      for (int k = 0; k < 40; k++) begin
         run(1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom % 3), 1'($urandom),
             1'($urandom), 1'($urandom), 1'($urandom), 13'($urandom), 1'($urandom), 1'($urandom));
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule